// File: doc/BRIEF.md
# Wrapping Read Address Sequencer

This block produces the page and column address for a streaming read or buffer transfer. The memory behind it holds 2048 pages of 264 bytes, and there are two 264-byte buffers. A command decoder loads a start page, a start column and an access mode. Each advance strobe then moves the address on by one byte, so the data path can fetch the next byte.

The three modes differ only in what happens when the last column of a unit has been passed. In whole-array streaming the sequence moves on to the next page, and after the last page it returns to page 0. In single-page reading it stays on the same page. In buffer access it stays in the same buffer. None of these wraps costs an idle cycle. A start column above the page size is accepted: the count runs on to the top of the 9-bit column field and only then applies the mode's wrap. The block does not serialise data and holds no storage.

Top module: `rd_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and in the first cycle after it, page_o and col_o are both 0.
- R2: When load_i is high at a rising clock edge, page_o and col_o show start_page_i and start_col_i after that edge. mode_i is captured at the same edge. Mode encoding: 0 = whole-array stream, 1 = single page, 2 or 3 = buffer.
- R3: If load_i and adv_i are both high at the same edge, the load wins and the advance is dropped.
- R4: With load_i and adv_i both low, page_o and col_o keep their values.
- R5: An advance from any column other than 263 and 511 adds one to col_o and leaves page_o unchanged, in every mode.
- R6: In whole-array mode, an advance from column 263 of page P (P below 2047) gives column 0 of page P+1 at the very next edge.
- R7: In whole-array mode, an advance from column 263 of page 2047 gives column 0 of page 0 at the very next edge.
- R8: In single-page mode, an advance from column 263 gives column 0 and leaves page_o unchanged.
- R9: In buffer mode, an advance from column 263 gives column 0 and leaves page_o unchanged.
- R10: A start column from 264 to 510 counts up to 511. An advance from 511 then wraps to column 0 by the rule of the captured mode: next page in whole-array mode, same page otherwise.
- R11: mode_i is ignored in any cycle without load_i. Only the mode captured at the last load decides the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture start address and mode |
| mode_i | input | 2 | Access mode, sampled only on load |
| start_page_i | input | 11 | Start page |
| start_col_i | input | 9 | Start column within the page or buffer |
| adv_i | input | 1 | Advance by one byte |
| page_o | output | 11 | Current page address |
| col_o | output | 9 | Current column address |

## Verification
Both address outputs come straight from registers. A wrong internal value therefore shows on page_o or col_o one edge after the load or advance that caused it. A wrong captured mode stays hidden until the next wrap. The tests therefore place wraps just after loads and after mode_i has been changed without a load, so a stale or wrongly captured mode shows up within a few cycles. Wrap points at column 263 and column 511, and at the last page, each get a start address one or a few bytes before the boundary. A missed or extra wrap, or a stall, then shows on the very next edge.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    localparam int PAGE_W     = 11;
    localparam int COL_W      = 9;
    localparam int NUM_PAGES  = 2048;
    localparam int PAGE_BYTES = 264;
    localparam int LAST_PAGE  = NUM_PAGES - 1;
    localparam int LAST_COL   = PAGE_BYTES - 1;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [COL_W-1:0]  col_t;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_PAGE   = 2'd1,
        MODE_BUF    = 2'd2,
        MODE_BUF_HI = 2'd3
    } rd_mode_e;

    typedef struct packed {
        page_t    page;
        col_t     col;
        rd_mode_e mode;
    } seq_state_t;
endpackage

// File: rtl/rsq_col_step.sv
module rsq_col_step
    import rsq_pkg::*;
#(
    parameter int CW       = COL_W,
    parameter int LAST_IDX = LAST_COL
) (
    input  logic [CW-1:0] col_i,
    output logic [CW-1:0] col_nxt_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] LAST_V = CW'(LAST_IDX);
    localparam logic [CW-1:0] TOP_V  = {CW{1'b1}};

    // Wrap at the last real column, or at the top of the field for out-of-range starts
    always_comb begin
        wrap_o    = (col_i == LAST_V) || (col_i == TOP_V);
        col_nxt_o = wrap_o ? '0 : col_i + CW'(1);
    end
endmodule

// File: rtl/rsq_page_step.sv
module rsq_page_step
    import rsq_pkg::*;
#(
    parameter int PW     = PAGE_W,
    parameter int NPAGES = NUM_PAGES
) (
    input  logic [PW-1:0] page_i,
    input  logic          wrap_i,
    input  rd_mode_e      mode_i,
    output logic [PW-1:0] page_nxt_o
);
    logic [PW-1:0] succ;

    generate
        if (NPAGES == (1 << PW)) begin : g_pow2
            // Full field: natural overflow returns to page 0
            assign succ = page_i + PW'(1);
        end else begin : g_cmp
            localparam logic [PW-1:0] TOP_PAGE = PW'(NPAGES - 1);
            assign succ = (page_i == TOP_PAGE) ? '0 : page_i + PW'(1);
        end
    endgenerate

    always_comb begin
        page_nxt_o = page_i;
        if (wrap_i && (mode_i == MODE_ARRAY)) begin
            page_nxt_o = succ;
        end
    end
endmodule

// File: rtl/rd_addr_seq.sv
module rd_addr_seq
    import rsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [1:0]        mode_i,
    input  logic [PAGE_W-1:0] start_page_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic              adv_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [COL_W-1:0]  col_o
);
    seq_state_t state_d, state_q;
    col_t       col_nxt;
    page_t      page_nxt;
    logic       col_wrap;

    rsq_col_step #(.CW(COL_W), .LAST_IDX(LAST_COL)) u_col (
        .col_i     (state_q.col),
        .col_nxt_o (col_nxt),
        .wrap_o    (col_wrap)
    );

    rsq_page_step #(.PW(PAGE_W), .NPAGES(NUM_PAGES)) u_page (
        .page_i     (state_q.page),
        .wrap_i     (col_wrap),
        .mode_i     (state_q.mode),
        .page_nxt_o (page_nxt)
    );

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.page = start_page_i;
            state_d.col  = start_col_i;
            state_d.mode = rd_mode_e'(mode_i);
        end else if (adv_i) begin
            state_d.page = page_nxt;
            state_d.col  = col_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{page: '0, col: '0, mode: MODE_ARRAY};
        end else begin
            state_q <= state_d;
        end
    end

    assign page_o = state_q.page;
    assign col_o  = state_q.col;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
    import rsq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [1:0]        mode_i,
    input logic [PAGE_W-1:0] start_page_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic              adv_i,
    input logic [PAGE_W-1:0] page_o,
    input logic [COL_W-1:0]  col_o
);
    localparam logic [COL_W-1:0]  C_LAST = COL_W'(LAST_COL);
    localparam logic [COL_W-1:0]  C_TOP  = {COL_W{1'b1}};
    localparam logic [PAGE_W-1:0] P_LAST = PAGE_W'(LAST_PAGE);

    // Independent record of the mode in force, built from the ports (R11)
    logic [1:0] md_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      md_q <= 2'd0;
        else if (load_i) md_q <= mode_i;
    end

    logic at_wrap;
    assign at_wrap = (col_o == C_LAST) || (col_o == C_TOP);

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (page_o == $past(start_page_i)) && (col_o == $past(start_col_i)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(page_o) && $stable(col_o));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && !at_wrap) |=>
            (col_o == $past(col_o) + COL_W'(1)) && $stable(page_o));

    a_r6_next_page: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && at_wrap && md_q == 2'd0 && page_o != P_LAST) |=>
            (col_o == '0) && (page_o == $past(page_o) + PAGE_W'(1)));

    a_r7_array_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && at_wrap && md_q == 2'd0 && page_o == P_LAST) |=>
            (col_o == '0) && (page_o == '0));

    // R8, R9, R10: same-unit wrap for page and buffer modes
    a_r8_same_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && at_wrap && md_q != 2'd0) |=>
            (col_o == '0) && $stable(page_o));
endmodule

bind rd_addr_seq rsq_checker u_chk (.*);

// File: tb/rd_addr_seq_bench.sv
`timescale 1ns/1ps
module rd_addr_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [10:0] start_page_i = '0;
    logic [8:0]  start_col_i = '0;
    logic        adv_i = 1'b0;
    logic [10:0] page_o;
    logic [8:0]  col_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rd_addr_seq u_rd_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .mode_i(mode_i),
        .start_page_i(start_page_i), .start_col_i(start_col_i),
        .adv_i(adv_i), .page_o(page_o), .col_o(col_o)
    );

    task automatic check(input string req, input int exp_page, input int exp_col);
        checks++;
        if (page_o !== 11'(exp_page) || col_o !== 9'(exp_col)) begin
            errors++;
            $display("FAIL %s: page=%0d col=%0d expected page=%0d col=%0d",
                     req, page_o, col_o, exp_page, exp_col);
        end
    endtask

    // All tasks begin and end just after a falling edge
    task automatic do_load(input int p, input int c, input int m);
        load_i = 1'b1; start_page_i = 11'(p); start_col_i = 9'(c); mode_i = 2'(m);
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic advance(input int n);
        adv_i = 1'b1;
        repeat (n) @(negedge clk);
        adv_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset", 0, 0);
    endtask

    task automatic t_load_step_hold;
        do_load(5, 10, 0);
        check("R2 load", 5, 10);
        advance(3);
        check("R5 step", 5, 13);
        repeat (3) @(negedge clk);
        check("R4 hold", 5, 13);
    endtask

    task automatic t_array_next_page;
        do_load(7, 262, 0);
        advance(1);
        check("R5 before edge", 7, 263);
        advance(1);
        check("R6 next page", 8, 0);
        advance(1);
        check("R6 no stall", 8, 1);
    endtask

    task automatic t_array_wrap;
        do_load(2047, 263, 0);
        advance(1);
        check("R7 array wrap", 0, 0);
    endtask

    task automatic t_page_mode;
        do_load(9, 263, 1);
        advance(1);
        check("R8 page wrap", 9, 0);
        advance(2);
        check("R8 after wrap", 9, 2);
    endtask

    task automatic t_buffer_mode;
        do_load(3, 260, 2);
        advance(4);
        check("R9 buffer wrap", 3, 0);
        do_load(12, 263, 3);
        advance(1);
        check("R9 buffer code 3", 12, 0);
    endtask

    task automatic t_out_of_range;
        do_load(10, 500, 0);
        advance(11);
        check("R10 reach 511", 10, 511);
        advance(1);
        check("R10 array wrap from 511", 11, 0);
        do_load(40, 510, 1);
        advance(2);
        check("R10 page wrap from 511", 40, 0);
        do_load(41, 300, 2);
        advance(1);
        check("R10 no early wrap", 41, 301);
    endtask

    task automatic t_load_priority;
        do_load(1, 1, 0);
        adv_i = 1'b1;
        do_load(20, 100, 0);
        adv_i = 1'b0;
        check("R3 load over advance", 20, 100);
    endtask

    task automatic t_mode_ignored;
        do_load(4, 263, 1);
        mode_i = 2'd0;
        @(negedge clk);
        advance(1);
        check("R11 mode ignored (page kept)", 4, 0);
        do_load(6, 263, 0);
        mode_i = 2'd2;
        @(negedge clk);
        advance(1);
        check("R11 mode ignored (array kept)", 7, 0);
    endtask

    task automatic t_reset_midrun;
        do_load(300, 50, 0);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_step_hold();
        t_array_next_page();
        t_array_wrap();
        t_page_mode();
        t_buffer_mode();
        t_out_of_range();
        t_load_priority();
        t_mode_ignored();
        t_reset_midrun();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule